// File: doc/BRIEF.md
# Serial Command Receiver with Ramp-Down Power Control

This block takes 8-bit commands from a host over a three-wire serial link. The link has an active-low chip select, a serial clock and a data line. All three lines are sampled by the block's own system clock through synchronisers, and serial clock edges are found in that domain. A command is carried out only when chip select returns high after exactly eight bits. It can power the output path down at once, power it down through a gradual ramp, pause or resume playback, or latch a small status-select field.

The block holds the present output level as an 8-bit register that the playback path loads. A ramped power-down lowers that level by a fixed step on each sample tick while busy is reported. When the level reaches zero, busy falls and power-down rises in the same cycle. While powered down, the level stays at zero. Any falling edge on chip select wakes the block, and the level is still zero at that point.

Top module: `sercmd_pwr_ctrl`

## Requirements
- R1: Bits are shifted in MSB first on each rising `sclk` edge seen while `cs_n` is low. A rising `cs_n` carries out the command only if exactly 8 bits arrived; with any other count nothing changes.
- R2: Command E1h sets `pdown`, forces `lvl_out` to 00h and leaves `busy` low.
- R3: Command A9h raises `busy`. While busy, every `sample_tick` lowers `lvl_out` by `RAMP_STEP`.
- R4: On a tick during the ramp where `lvl_out` is at or below `RAMP_STEP`, the level becomes 00h, `busy` falls and `pdown` rises, all in the same cycle. `busy` and `pdown` are never high together.
- R5: Command 39h sets `paused` and command 1Dh clears it. While paused, `lvl_load` has no effect on `lvl_out`.
- R6: A command whose upper five bits are 10000b copies its low three bits into `stat_sel`.
- R7: Any other opcode changes none of the outputs.
- R8: While `busy` is high, every received command is ignored.
- R9: While `pdown` is high, a falling `cs_n` clears `pdown`, and `lvl_out` stays 00h.
- R10: After reset, `lvl_out`, `busy`, `paused`, `pdown` and `stat_sel` are all zero.
- R11: While `pdown` is high, `lvl_out` is 00h and `lvl_load` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sample_tick | input | 1 | One-cycle pulse per audio sample |
| lvl_load | input | 1 | Load strobe from the playback path |
| lvl_in | input | 8 | Level value from the playback path |
| lvl_out | output | 8 | Present output level |
| busy | output | 1 | High during a ramped power-down |
| paused | output | 1 | Playback paused |
| pdown | output | 1 | Powered down |
| stat_sel | output | 3 | Latched status-select field |

## Verification
Four invariants are checked on every cycle:
- `busy` and `pdown` are never high together.
- The level never rises while a ramp runs.
- The level is zero whenever the block is powered down.
- The level holds still while the block is paused and idle.

Other behaviours show up only in the bench's scenarios:
- The exact stride of the ramp and the cycle in which it ends.
- Rejection of frames with seven or nine bits.
- Immunity to commands sent during a ramp.
- Wake-up on chip select.
- Decoding of random opcodes.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;
  localparam int CMD_W  = 8;
  localparam int STAT_W = 3;
  typedef logic [CMD_W-1:0] cmd_t;

  localparam cmd_t OP_PD_NOW  = 8'hE1;
  localparam cmd_t OP_PD_RAMP = 8'hA9;
  localparam cmd_t OP_PAUSE   = 8'h39;
  localparam cmd_t OP_RESUME  = 8'h1D;
  localparam logic [CMD_W-STAT_W-1:0] OP_STAT_HI = 5'b10000;
endpackage

// File: rtl/sc_sync.sv
module sc_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  input  logic [WIDTH-1:0] rst_val,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= rst_val;
      else if (s == 0) stage_q[s] <= din;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/sc_shift.sv
module sc_shift
  import sercmd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cs_n_s,
  input  logic sclk_s,
  input  logic sdi_s,
  output logic cmd_vld,
  output cmd_t cmd,
  output logic cs_fall
);
  localparam int CNT_W   = $clog2(CMD_W + 2);
  localparam int CNT_SAT = CMD_W + 1;

  logic             sclk_q, cs_n_q;
  logic [CNT_W-1:0] bit_cnt;
  cmd_t             shreg;
  logic             sck_rise, cs_rise, cs_dn;

  assign sck_rise = sclk_s & ~sclk_q;
  assign cs_rise  = cs_n_s & ~cs_n_q;
  assign cs_dn    = ~cs_n_s & cs_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      bit_cnt <= '0;
      shreg   <= '0;
      cmd_vld <= 1'b0;
      cmd     <= '0;
      cs_fall <= 1'b0;
    end else begin
      sclk_q  <= sclk_s;
      cs_n_q  <= cs_n_s;
      cmd_vld <= 1'b0;
      cs_fall <= cs_dn;
      if (cs_dn) begin
        bit_cnt <= '0;
      end else if (!cs_n_s && sck_rise) begin
        shreg <= {shreg[CMD_W-2:0], sdi_s};
        if (bit_cnt != CNT_W'(CNT_SAT)) bit_cnt <= bit_cnt + 1'b1;
      end
      if (cs_rise) begin
        cmd_vld <= (bit_cnt == CNT_W'(CMD_W));
        cmd     <= shreg;
        bit_cnt <= '0;
      end
    end
  end

  // R1: a command is only presented right after chip select was released
  assert_vld_on_release_R1: assert property (@(posedge clk) disable iff (rst)
    cmd_vld |-> $past(cs_n_s) && cs_n_q);
endmodule

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sercmd_pkg::*;
#(
  parameter int LVL_W     = 8,
  parameter int RAMP_STEP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_vld,
  input  cmd_t              cmd,
  input  logic              cs_fall,
  input  logic              sample_tick,
  input  logic              lvl_load,
  input  logic [LVL_W-1:0]  lvl_in,
  output logic [LVL_W-1:0]  lvl,
  output logic              busy,
  output logic              paused,
  output logic              pdown,
  output logic [STAT_W-1:0] stat_sel
);
  localparam logic [LVL_W-1:0] STEP = LVL_W'(RAMP_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl      <= '0;
      busy     <= 1'b0;
      paused   <= 1'b0;
      pdown    <= 1'b0;
      stat_sel <= '0;
    end else if (busy) begin
      if (sample_tick) begin
        if (lvl <= STEP) begin
          lvl   <= '0;
          busy  <= 1'b0;
          pdown <= 1'b1;
        end else begin
          lvl <= lvl - STEP;
        end
      end
    end else begin
      if (pdown && cs_fall) pdown <= 1'b0;
      if (lvl_load && !paused && !pdown) lvl <= lvl_in;
      if (cmd_vld) begin
        case (cmd)
          OP_PD_NOW: begin
            pdown <= 1'b1;
            lvl   <= '0;
          end
          OP_PD_RAMP: busy   <= 1'b1;
          OP_PAUSE:   paused <= 1'b1;
          OP_RESUME:  paused <= 1'b0;
          default: begin
            if (cmd[CMD_W-1:STAT_W] == OP_STAT_HI) stat_sel <= cmd[STAT_W-1:0];
          end
        endcase
      end
    end
  end

  assert_busy_pdown_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(busy && pdown));

  assert_ramp_no_rise_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> lvl <= $past(lvl));

  assert_ramp_ends_pdown_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> pdown && lvl == '0);

  assert_pdown_zero_R11: assert property (@(posedge clk) disable iff (rst)
    pdown |-> lvl == '0);

  assert_pause_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (paused && $past(paused) && !busy && !pdown && !$past(busy) && !$past(pdown))
      |-> $stable(lvl));
endmodule

// File: rtl/sercmd_pwr_ctrl.sv
module sercmd_pwr_ctrl
  import sercmd_pkg::*;
#(
  parameter int LVL_W       = 8,
  parameter int RAMP_STEP   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              sample_tick,
  input  logic              lvl_load,
  input  logic [LVL_W-1:0]  lvl_in,
  output logic [LVL_W-1:0]  lvl_out,
  output logic              busy,
  output logic              paused,
  output logic              pdown,
  output logic [STAT_W-1:0] stat_sel
);
  logic [2:0] pins_s;
  logic       cmd_vld, cs_fall;
  cmd_t       cmd;

  sc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .din     ({cs_n, sclk, sdi}),
    .rst_val (3'b100),
    .dout    (pins_s)
  );

  sc_shift u_shift (
    .clk     (clk),
    .rst     (rst),
    .cs_n_s  (pins_s[2]),
    .sclk_s  (pins_s[1]),
    .sdi_s   (pins_s[0]),
    .cmd_vld (cmd_vld),
    .cmd     (cmd),
    .cs_fall (cs_fall)
  );

  sc_ctrl #(.LVL_W(LVL_W), .RAMP_STEP(RAMP_STEP)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cmd_vld     (cmd_vld),
    .cmd         (cmd),
    .cs_fall     (cs_fall),
    .sample_tick (sample_tick),
    .lvl_load    (lvl_load),
    .lvl_in      (lvl_in),
    .lvl         (lvl_out),
    .busy        (busy),
    .paused      (paused),
    .pdown       (pdown),
    .stat_sel    (stat_sel)
  );
endmodule

// File: tb/sercmd_pwr_ctrl_bench.sv
module sercmd_pwr_ctrl_bench;
  localparam int STEP = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic       sample_tick = 1'b0, lvl_load = 1'b0;
  logic [7:0] lvl_in = '0;
  logic [7:0] lvl_out;
  logic       busy, paused, pdown;
  logic [2:0] stat_sel;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [7:0] e_lvl;
  logic       e_busy, e_paused, e_pd;
  logic [2:0] e_stat;

  always #2.5 clk = ~clk;

  sercmd_pwr_ctrl #(.RAMP_STEP(STEP)) u_sercmd_pwr_ctrl (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sample_tick(sample_tick), .lvl_load(lvl_load), .lvl_in(lvl_in),
    .lvl_out(lvl_out), .busy(busy), .paused(paused), .pdown(pdown),
    .stat_sel(stat_sel)
  );

  function automatic logic [7:0] ramp_next(input logic [7:0] l);
    return (l <= 8'(STEP)) ? 8'h00 : l - 8'(STEP);
  endfunction

  function automatic bit is_known(input logic [7:0] op);
    return op == 8'hE1 || op == 8'hA9 || op == 8'h39 || op == 8'h1D || op[7:3] == 5'b10000;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " lvl"}, 32'(lvl_out), 32'(e_lvl));
    chk({req, " busy"}, 32'(busy), 32'(e_busy));
    chk({req, " paused"}, 32'(paused), 32'(e_paused));
    chk({req, " pdown"}, 32'(pdown), 32'(e_pd));
    chk({req, " stat"}, 32'(stat_sel), 32'(e_stat));
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] val, input int nbits);
    cs_n = 1'b0;
    wclk(4);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 8) ? val[7-i] : 1'b0;
      wclk(4);
      sclk = 1'b1;
      wclk(4);
      sclk = 1'b0;
    end
    wclk(4);
    cs_n = 1'b1;
    wclk(10);
  endtask

  task automatic load(input logic [7:0] v);
    lvl_in = v;
    lvl_load = 1'b1;
    wclk(1);
    lvl_load = 1'b0;
    wclk(2);
  endtask

  task automatic tick();
    sample_tick = 1'b1;
    wclk(1);
    sample_tick = 1'b0;
    wclk(2);
  endtask

  task automatic model_cmd(input logic [7:0] op);
    if (e_busy) return;
    if (e_pd) e_pd = 1'b0;
    case (op)
      8'hE1: begin e_pd = 1'b1; e_lvl = 8'h00; end
      8'hA9: e_busy = 1'b1;
      8'h39: e_paused = 1'b1;
      8'h1D: e_paused = 1'b0;
      default: if (op[7:3] == 5'b10000) e_stat = op[2:0];
    endcase
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] op, l;
    void'($urandom(32'd4711));
    e_lvl = 0; e_busy = 0; e_paused = 0; e_pd = 0; e_stat = 0;
    wclk(6);
    rst = 1'b0;
    wclk(2);
    chk_all("R10 reset");

    load(8'h5A); e_lvl = 8'h5A;
    chk_all("R11 load idle");

    // R1 seven and nine bit frames are discarded
    send(8'hE1, 7);
    chk_all("R1 short frame");
    send(8'hE1, 9);
    chk_all("R1 long frame");

    // R6 status field
    send(8'h85, 8); model_cmd(8'h85);
    chk_all("R6 status");

    // R5 pause blocks loads, resume re-enables
    send(8'h39, 8); model_cmd(8'h39);
    load(8'h11);
    chk_all("R5 paused load ignored");
    send(8'h1D, 8); model_cmd(8'h1D);
    load(8'h22); e_lvl = 8'h22;
    chk_all("R5 resumed load");

    // R7 unknown opcode
    send(8'h55, 8);
    chk_all("R7 unknown");

    // R2 immediate power-down, R11 load ignored, R9 wake
    send(8'hE1, 8); model_cmd(8'hE1);
    chk_all("R2 pd now");
    load(8'h33);
    chk_all("R11 pd load ignored");
    send(8'h1D, 8); model_cmd(8'h1D);
    chk_all("R9 wake");

    // R3 R4 R8 ramp from 10
    load(8'h0A); e_lvl = 8'h0A;
    send(8'hA9, 8); model_cmd(8'hA9);
    chk_all("R3 ramp start");
    send(8'hE1, 8); send(8'h83, 8);
    chk_all("R8 cmds during ramp ignored");
    load(8'hFF);
    chk_all("R3 load during ramp ignored");
    while (e_busy) begin
      tick();
      if (e_lvl <= 8'(STEP)) begin e_busy = 0; e_pd = 1; end
      e_lvl = ramp_next(e_lvl);
      chk_all("R3 R4 ramp step");
    end
    send(8'h82, 8); model_cmd(8'h82);
    chk_all("R9 wake after ramp");

    // R4 boundary: level exactly one step multiple
    load(8'h08); e_lvl = 8'h08;
    send(8'hA9, 8); model_cmd(8'hA9);
    tick(); e_lvl = 8'h04;
    chk_all("R3 ramp 8->4");
    tick(); e_lvl = 8'h00; e_busy = 0; e_pd = 1;
    chk_all("R4 ramp end exact");
    send(8'h1D, 8); model_cmd(8'h1D);

    // random mix
    for (int it = 0; it < 40; it++) begin
      case ($urandom % 5)
        0: begin
          l = 8'($urandom);
          load(l);
          if (!e_paused) e_lvl = l;
          chk_all("R5 R11 random load");
        end
        1: begin send(8'h39, 8); model_cmd(8'h39); chk_all("R5 random pause"); end
        2: begin send(8'h1D, 8); model_cmd(8'h1D); chk_all("R5 random resume"); end
        3: begin
          op = {5'b10000, 3'($urandom)};
          send(op, 8); model_cmd(op);
          chk_all("R6 random status");
        end
        default: begin
          op = 8'($urandom);
          if (is_known(op)) op = 8'h00;
          send(op, 8);
          chk_all("R7 random unknown");
        end
      endcase
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule